// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations. A lookup takes a virtual address. The upper bits, the virtual page number, are compared against every stored tag at once. The lowest-numbered valid row that matches supplies its payload from a separate storage array. The payload holds a physical frame number, a dirty bit and a few status bits. The page offset is not translated: it is copied straight into the physical address. The result is registered and appears one clock after the lookup strobe.

When a lookup misses, the surrounding logic walks the page table and then loads the translation through the fill port. The block picks the row to overwrite by itself. It takes the lowest empty row if there is one. Once every row is valid, it takes the row named by a round-robin pointer. A flush input clears every valid bit in a single cycle. The fill port does not check whether the page number is already present, so duplicate tags can occur. The block resolves them deterministically and raises a diagnostic flag when they are hit.

Top module: `tlb_cam`

## Requirements
- R1: After reset every row is invalid, rsp_valid_o is low and the round-robin pointer is 0, so the first lookup misses.
- R2: rsp_valid_o is high in exactly the cycle after a cycle with lookup_i high, and low otherwise.
- R3: A lookup hits when a valid row's tag equals va_i[31:12]; the response then has hit_o=1 and pa_o = {row frame, va_i[11:0]}. On a miss hit_o=0 and pa_o = {20'b0, va_i[11:0]}.
- R4: On a hit, dirty_o and status_o carry the matched row's stored bits; on a miss both are 0.
- R5: When several valid rows match, the lowest-index row supplies the response and multi_hit_o is 1; otherwise multi_hit_o is 0.
- R6: A fill writes the lowest-index invalid row when any row is invalid, and it leaves the round-robin pointer unchanged.
- R7: When all rows are valid, a fill writes the row at the round-robin pointer, and the pointer then advances by one, wrapping from ENTRIES-1 to 0.
- R8: flush_i clears every valid bit at the next edge; a fill in the same cycle is dropped.
- R9: A lookup in the same cycle as a fill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup strobe |
| va_i | input | VA_W | Virtual address to translate |
| flush_i | input | 1 | Invalidate all rows |
| fill_i | input | 1 | Write one translation |
| fill_vpn_i | input | VA_W-OFF_W | Virtual page number to store |
| fill_ppn_i | input | PPN_W | Physical frame number to store |
| fill_dirty_i | input | 1 | Dirty bit to store |
| fill_status_i | input | STAT_W | Status bits to store |
| rsp_valid_o | output | 1 | Lookup response valid |
| hit_o | output | 1 | Translation found |
| multi_hit_o | output | 1 | More than one row matched |
| pa_o | output | PPN_W+OFF_W | Physical address |
| dirty_o | output | 1 | Dirty bit of the matched row |
| status_o | output | STAT_W | Status bits of the matched row |

## Verification
The assertions check on every cycle the timing of the response strobe and the copy of the offset into the physical address. They also check that a miss returns a zeroed payload, that multi_hit_o never appears without a hit, that at most one row is written per cycle, and that a flush leaves no valid row. Which row a fill replaces, how the round-robin pointer advances, and which row wins among duplicate tags show only at the ports over a sequence of operations. The bench's behavioural model and its directed scenarios cover these, including the cases where a lookup coincides with a fill or a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_VA_W    = 32;
  localparam int unsigned DEF_OFF_W   = 12;
  localparam int unsigned DEF_PPN_W   = 20;
  localparam int unsigned DEF_STAT_W  = 3;

  typedef enum logic {
    VIC_FREE  = 1'b0,
    VIC_ROUND = 1'b1
  } vic_src_e;
endpackage

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [ENTRIES-1:0] we_i,
  input  logic [VPN_W-1:0]   wvpn_i,
  input  logic [VPN_W-1:0]   key_i,
  output logic [ENTRIES-1:0] match_o,
  output logic [ENTRIES-1:0] valid_o
);
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (we_i[g]) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wvpn_i;
      end
    end
    assign match_o[g] = valid_q[g] && (tag_q[g] == key_i);
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o,
  output logic               multi_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |req_i;
  assign multi_o = $countones(req_i) > 1;
endmodule

// File: rtl/tlb_payload_ram.sv
module tlb_payload_ram #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PL_W    = 24,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] we_i,
  input  logic [PL_W-1:0]    wdata_i,
  input  logic [IDX_W-1:0]   ridx_i,
  output logic [PL_W-1:0]    rdata_o
);
  logic [PL_W-1:0] mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_q[g] <= '0;
      else if (we_i[g]) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               fill_go_i,
  output logic [IDX_W-1:0]   victim_o
);
  import tlb_pkg::*;

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  vic_src_e         src;

  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_free_enc (
    .req_i  (~valid_i),
    .idx_o  (free_idx),
    .any_o  (free_any),
    .multi_o()
  );

  assign src      = free_any ? VIC_FREE : VIC_ROUND;
  assign victim_o = (src == VIC_FREE) ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_go_i && src == VIC_ROUND) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned VA_W    = tlb_pkg::DEF_VA_W,
  parameter int unsigned OFF_W   = tlb_pkg::DEF_OFF_W,
  parameter int unsigned PPN_W   = tlb_pkg::DEF_PPN_W,
  parameter int unsigned STAT_W  = tlb_pkg::DEF_STAT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lookup_i,
  input  logic [VA_W-1:0]          va_i,
  input  logic                     flush_i,
  input  logic                     fill_i,
  input  logic [VA_W-OFF_W-1:0]    fill_vpn_i,
  input  logic [PPN_W-1:0]         fill_ppn_i,
  input  logic                     fill_dirty_i,
  input  logic [STAT_W-1:0]        fill_status_i,
  output logic                     rsp_valid_o,
  output logic                     hit_o,
  output logic                     multi_hit_o,
  output logic [PPN_W+OFF_W-1:0]   pa_o,
  output logic                     dirty_o,
  output logic [STAT_W-1:0]        status_o
);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned PL_W  = PPN_W + 1 + STAT_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;

  logic [ENTRIES-1:0] entry_match;
  logic [ENTRIES-1:0] entry_valid;
  logic [ENTRIES-1:0] fill_we;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic               any_hit;
  logic               many_hit;
  logic               fill_go;
  logic [PL_W-1:0]    rd_pl;
  logic [PL_W-1:0]    wr_pl;

  // flush has priority over fill
  assign fill_go = fill_i && !flush_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_we
    assign fill_we[g] = fill_go && (victim == IDX_W'(g));
  end

  assign wr_pl = {fill_dirty_i, fill_status_i, fill_ppn_i};

  tlb_tag_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .we_i   (fill_we),
    .wvpn_i (fill_vpn_i),
    .key_i  (va_i[VA_W-1:OFF_W]),
    .match_o(entry_match),
    .valid_o(entry_valid)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_hit_enc (
    .req_i  (entry_match),
    .idx_o  (hit_idx),
    .any_o  (any_hit),
    .multi_o(many_hit)
  );

  tlb_payload_ram #(.ENTRIES(ENTRIES), .PL_W(PL_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fill_we),
    .wdata_i(wr_pl),
    .ridx_i (hit_idx),
    .rdata_o(rd_pl)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_vic (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (entry_valid),
    .fill_go_i(fill_go),
    .victim_o (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      multi_hit_o <= 1'b0;
      pa_o        <= '0;
      dirty_o     <= 1'b0;
      status_o    <= '0;
    end else begin
      rsp_valid_o <= lookup_i;
      if (lookup_i) begin
        hit_o       <= any_hit;
        multi_hit_o <= many_hit;
        pa_o        <= {any_hit ? rd_pl[PPN_W-1:0] : PPN_W'(0), va_i[OFF_W-1:0]};
        dirty_o     <= any_hit && rd_pl[PL_W-1];
        status_o    <= any_hit ? rd_pl[PPN_W +: STAT_W] : '0;
      end
    end
  end

  logic [PA_W-1:0] unused_pa_w;
  assign unused_pa_w = '0;
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned STAT_W  = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lookup_i,
  input logic [VA_W-1:0]        va_i,
  input logic                   flush_i,
  input logic                   rsp_valid_o,
  input logic                   hit_o,
  input logic                   multi_hit_o,
  input logic [PPN_W+OFF_W-1:0] pa_o,
  input logic                   dirty_o,
  input logic [STAT_W-1:0]      status_o,
  input logic [ENTRIES-1:0]     entry_valid,
  input logic [ENTRIES-1:0]     fill_we
);
  assert_rsp_after_lookup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> rsp_valid_o);
  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> !rsp_valid_o);
  assert_offset_passthru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> pa_o[OFF_W-1:0] == $past(va_i[OFF_W-1:0]));
  assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !hit_o) |-> (!dirty_o && status_o == '0 && pa_o[PPN_W+OFF_W-1:OFF_W] == '0));
  assert_multi_needs_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);
  assert_one_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_we));
  assert_flush_drops_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> fill_we == '0);
  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> entry_valid == '0);
endmodule

bind tlb_cam tlb_cam_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .STAT_W(STAT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lookup_i   (lookup_i),
  .va_i       (va_i),
  .flush_i    (flush_i),
  .rsp_valid_o(rsp_valid_o),
  .hit_o      (hit_o),
  .multi_hit_o(multi_hit_o),
  .pa_o       (pa_o),
  .dirty_o    (dirty_o),
  .status_o   (status_o),
  .entry_valid(entry_valid),
  .fill_we    (fill_we)
);

// File: tb/tlb_cam_tb_top.sv
module tlb_cam_tb_top;
  localparam int N  = 4;
  localparam int ST = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup = 1'b0;
  logic [31:0] va = '0;
  logic        flush = 1'b0;
  logic        fill = 1'b0;
  logic [19:0] f_vpn = '0;
  logic [19:0] f_ppn = '0;
  logic        f_dirty = 1'b0;
  logic [ST-1:0] f_stat = '0;
  logic        rsp_valid, hit, multi, dirty;
  logic [31:0] pa;
  logic [ST-1:0] stat;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  tlb_cam #(.ENTRIES(N), .STAT_W(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .va_i(va), .flush_i(flush),
    .fill_i(fill), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_dirty_i(f_dirty),
    .fill_status_i(f_stat), .rsp_valid_o(rsp_valid), .hit_o(hit), .multi_hit_o(multi),
    .pa_o(pa), .dirty_o(dirty), .status_o(stat)
  );

  // behavioural reference
  bit          m_v [N];
  bit [19:0]   m_vpn [N];
  bit [19:0]   m_ppn [N];
  bit          m_d [N];
  bit [ST-1:0] m_s [N];
  int          m_rr = 0;
  bit          e_vld = 0, e_hit = 0, e_multi = 0, e_d = 0;
  bit [31:0]   e_pa = '0;
  bit [ST-1:0] e_s = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_rr = 0; e_vld = 0;
    end else begin
      int found; int cnt; int vic;
      e_vld = lookup;
      if (lookup) begin
        found = -1; cnt = 0;
        for (int i = 0; i < N; i++)
          if (m_v[i] && m_vpn[i] == va[31:12]) begin
            cnt++;
            if (found < 0) found = i;
          end
        e_hit = found >= 0; e_multi = cnt > 1;
        e_pa  = {e_hit ? m_ppn[found] : 20'd0, va[11:0]};
        e_d   = e_hit ? m_d[found] : 1'b0;
        e_s   = e_hit ? m_s[found] : '0;
      end
      if (flush) begin
        foreach (m_v[i]) m_v[i] = 0;
      end else if (fill) begin
        vic = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[vic] = 1; m_vpn[vic] = f_vpn; m_ppn[vic] = f_ppn;
        m_d[vic] = f_dirty; m_s[vic] = f_stat;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    chk(rsp_valid == e_vld, "R2 rsp_valid", 32'(rsp_valid), 32'(e_vld));
    if (e_vld && rsp_valid) begin
      chk(hit == e_hit, "R3 hit", 32'(hit), 32'(e_hit));
      chk(pa == e_pa, "R3 pa", pa, e_pa);
      chk(dirty == e_d && stat == e_s, "R4 dirty/status", {28'd0, dirty, stat}, {28'd0, e_d, e_s});
      chk(multi == e_multi, "R5 multi", 32'(multi), 32'(e_multi));
    end
  end

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic d, input logic [ST-1:0] s);
    fill = 1; f_vpn = v; f_ppn = p; f_dirty = d; f_stat = s;
    @(negedge clk);
    fill = 0;
  endtask

  // directed lookup with literal expectation, checked one cycle later
  task automatic look(input logic [31:0] a, input bit ehit, input logic [19:0] eppn,
                      input bit emulti, input string tag);
    lookup = 1; va = a;
    @(negedge clk);
    lookup = 0;
    chk(hit == ehit, tag, 32'(hit), 32'(ehit));
    if (ehit) chk(pa == {eppn, a[11:0]}, tag, pa, {eppn, a[11:0]});
    chk(multi == emulti, tag, 32'(multi), 32'(emulti));
  endtask

  task automatic finish_tb;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && hit == 0, "R1 reset outputs", {30'd0, rsp_valid, hit}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    look(32'h0000_0abc, 0, 20'd0, 0, "R1 first lookup misses");

    // free rows fill in index order
    do_fill(20'h00001, 20'hA0001, 1, 3'd5);
    do_fill(20'h00002, 20'hA0002, 0, 3'd2);
    look(32'h0000_1123, 1, 20'hA0001, 0, "R6 row0 fill");
    chk(dirty == 1 && stat == 3'd5, "R4 payload bits", {28'd0, dirty, stat}, 32'hd);
    look(32'h0000_2fff, 1, 20'hA0002, 0, "R6 row1 fill");
    look(32'h0000_3000, 0, 20'd0, 0, "R3 miss");
    do_fill(20'h00003, 20'hA0003, 0, 3'd1);
    do_fill(20'h00004, 20'hA0004, 1, 3'd7);

    // full: round robin from 0
    do_fill(20'h00005, 20'hA0005, 0, 3'd0);
    look(32'h0000_1000, 0, 20'd0, 0, "R7 row0 replaced");
    look(32'h0000_5001, 1, 20'hA0005, 0, "R7 new at row0");
    do_fill(20'h00006, 20'hA0006, 0, 3'd0);
    look(32'h0000_2000, 0, 20'd0, 0, "R7 row1 replaced");

    // pointer at 2: duplicate of row3's page lands in row2
    do_fill(20'h00004, 20'hB0004, 0, 3'd3);
    look(32'h0000_4044, 1, 20'hB0004, 1, "R5 lowest row wins");
    do_fill(20'h00007, 20'hA0007, 0, 3'd0);  // row3, pointer wraps
    look(32'h0000_4044, 1, 20'hB0004, 0, "R5 single match");
    do_fill(20'h00008, 20'hA0008, 0, 3'd0);  // row0 after wrap
    look(32'h0000_5000, 0, 20'd0, 0, "R7 wrap to row0");

    // lookup concurrent with fill sees old contents
    lookup = 1; va = 32'h0000_9010;
    fill = 1; f_vpn = 20'h00009; f_ppn = 20'hA0009; f_dirty = 0; f_stat = 0;
    @(negedge clk);
    lookup = 0; fill = 0;
    chk(hit == 0, "R9 lookup with fill", 32'(hit), 32'd0);
    look(32'h0000_9010, 1, 20'hA0009, 0, "R9 fill visible next");

    // flush with simultaneous fill and lookup
    lookup = 1; va = 32'h0000_9010; flush = 1;
    fill = 1; f_vpn = 20'h0000C; f_ppn = 20'hA000C;
    @(negedge clk);
    lookup = 0; flush = 0; fill = 0;
    chk(hit == 1, "R9 lookup with flush", 32'(hit), 32'd1);
    look(32'h0000_9010, 0, 20'd0, 0, "R8 flushed");
    look(32'h0000_C000, 0, 20'd0, 0, "R8 fill dropped");
    do_fill(20'h0000D, 20'hA000D, 0, 3'd0);
    look(32'h0000_D000, 1, 20'hA000D, 0, "R6 refill after flush");

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      lookup = $urandom_range(0, 1) != 0;
      va = {17'd0, 3'($urandom_range(0, 5)), 12'($urandom)};
      fill = $urandom_range(0, 3) == 0;
      f_vpn = {17'd0, 3'($urandom_range(0, 5))};
      f_ppn = 20'($urandom); f_dirty = 1'($urandom); f_stat = ST'($urandom);
      flush = $urandom_range(0, 29) == 0;
      @(negedge clk);
    end
    lookup = 0; fill = 0; flush = 0;
    @(negedge clk);
    finish_tb();
  end
endmodule